// File: doc/BRIEF.md
# Scrambled PWM Scan Sequencer

This block is the display engine of a time-multiplexed LED driver, running on the grayscale clock. Each channel's stored grayscale word is not shown as one long pulse per frame. It is cut into many short PWM sections that are spread across the frame. Every section is shown once on every scan line before the next section starts, which raises the visual refresh rate by the number of sections. Each section has a fixed number of PWM clocks. The upper field of the word sets the pulse width that every section gets. The lower field gives one extra clock to a subset of sections, and that subset is chosen through a bit-reversed section index so the extra clocks are spread evenly.

A configurable dead-time slot follows each section. During that slot all outputs are dark and the scan line index advances. A lower-ghost discharge strobe can optionally be asserted across the whole slot. A hold input keeps the sequencer parked in the last dead-time clock, so the scan line cannot move while open-circuit detection runs. A short mode halves both the section length and the section count and reads a narrower grayscale field. The grayscale words for the line shown on `line_o` are supplied by the surrounding display bank, combinationally on `gray_i`.

Top module: `spwm_scan_seq`

## Requirements
- R1: In full mode (short_mode_i=0) each slot has 2^SLOT_BITS PWM clocks followed by the dead time, and one PWM cycle has 2^SEC_BITS sections. A word is split with value[W-1:SEC_BITS] as the width field and value[SEC_BITS-1:0] as the spread field, where W=SLOT_BITS+SEC_BITS.
- R2: In short mode (short_mode_i=1) a slot has 2^(SLOT_BITS-1) PWM clocks and a cycle has 2^(SEC_BITS-1) sections. The width field is value[W-1:SEC_BITS+1], the spread field is value[SEC_BITS:2], and value[1:0] is ignored.
- R3: Within a slot, channel output oe_o[c] is high on PWM clocks 0 to L-1 and low afterwards, where L is the width field plus any extra clock. A width field of 1 with no extra clock gives a single-clock pulse.
- R4: Section s receives one extra clock when the bit-reversed section index, reversed over the section-index width of the current mode, is less than the spread field.
- R5: A grayscale word of zero keeps its channel off in every section.
- R6: During dead time all oe_o bits are 0. The dead time lasts dead_len_i clocks, and a value of 0 is treated as 1.
- R7: line_o advances by one at the end of each dead time and wraps to 0 after line lines_i, so that lines_i+1 lines are scanned. The section index advances only when line_o wraps, and the sections wrap at the end of the PWM cycle.
- R8: ghost_o is high in every dead-time clock when ghost_en_i=1, and is low otherwise.
- R9: While hold_i=1 the sequencer stops in the last dead-time clock: line_o is frozen, outputs stay dark, and ghost_o follows R8. On the first clock edge after hold_i falls, line_o advances.
- R10: While rst_ni=0, line_o is 0 and ghost_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Grayscale clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| gray_i | input | CH*W | Grayscale words of the line shown on line_o, channel c at [c*W +: W] |
| short_mode_i | input | 1 | 1 selects half-length slots and half the sections |
| ghost_en_i | input | 1 | Enables the discharge strobe in dead time |
| dead_len_i | input | DEAD_W | Dead-time length in clocks (0 acts as 1) |
| lines_i | input | LINE_W | Number of scan lines minus one |
| hold_i | input | 1 | Parks the sequencer in the last dead-time clock |
| oe_o | output | CH | Channel output enables |
| line_o | output | LINE_W | Active scan line index |
| ghost_o | output | 1 | Lower-ghost discharge strobe |

## Verification
The sensitive meeting point is the last clock of a slot. There, the last PWM clock of a channel given a full-width pulse (maximum width field plus its extra clock) is followed at once by the dead time, the scan-line step and the strobe rise. A line wrap can also bring a section step in the same cycle. The bench provokes this by sweeping every grayscale code on every channel and line, in both modes and with the shortest dead time. It compares each clock against a position computed arithmetically from the cycle count since reset, so a pulse that runs one clock into the dead time, or a line step taken one clock early, shows as a mismatch at that exact cycle. A hold raised mid-slot checks that the park lands on the dead-time clock and that the step follows the release edge.

// File: rtl/spwm_pkg.sv
package spwm_pkg;

  // Reverse the low n bits of v (n <= 16).
  function automatic logic [31:0] rev_bits(input logic [31:0] v, input int n);
    logic [31:0] r;
    r = '0;
    for (int i = 0; i < 16; i++) begin
      if (i < n) r[n-1-i] = v[i];
    end
    return r;
  endfunction

  // Number of PWM clocks a channel stays on in a given section.
  function automatic logic [31:0] on_clocks(input logic [31:0] v, input logic [31:0] sec,
                                            input logic short_m, input int slot_b,
                                            input int sec_b);
    logic [31:0] hi;
    logic [31:0] lo;
    int nb;
    if (short_m) begin
      nb = sec_b - 1;
      hi = (v >> (sec_b + 1)) & ((32'd1 << (slot_b - 1)) - 32'd1);
      lo = (v >> 2) & ((32'd1 << nb) - 32'd1);
    end else begin
      nb = sec_b;
      hi = (v >> sec_b) & ((32'd1 << slot_b) - 32'd1);
      lo = v & ((32'd1 << nb) - 32'd1);
    end
    return hi + ((rev_bits(sec, nb) < lo) ? 32'd1 : 32'd0);
  endfunction

endpackage

// File: rtl/spwm_timer.sv
module spwm_timer #(
  parameter int SLOT_BITS = 10,
  parameter int SEC_BITS  = 6,
  parameter int DEAD_W    = 6,
  parameter int LINE_W    = 4,
  parameter int CNT_W     = ((SLOT_BITS > DEAD_W) ? SLOT_BITS : DEAD_W) + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                short_i,
  input  logic [DEAD_W-1:0]   dead_len_i,
  input  logic [LINE_W-1:0]   lines_i,
  input  logic                hold_i,
  output logic [CNT_W-1:0]    cnt_o,
  output logic [SEC_BITS-1:0] sec_o,
  output logic [LINE_W-1:0]   line_o,
  output logic                dead_o,
  output logic                last_o
);

  logic [CNT_W-1:0]    cnt_q;
  logic [SEC_BITS-1:0] sec_q;
  logic [LINE_W-1:0]   line_q;
  logic [CNT_W-1:0]    slot_len, dead_eff, last_pos;
  logic [SEC_BITS-1:0] sec_last;

  assign slot_len = short_i ? (CNT_W'(1) << (SLOT_BITS - 1)) : (CNT_W'(1) << SLOT_BITS);
  assign dead_eff = (dead_len_i == '0) ? CNT_W'(1) : CNT_W'(dead_len_i);
  assign last_pos = slot_len + dead_eff - CNT_W'(1);
  assign sec_last = short_i ? SEC_BITS'((1 << (SEC_BITS - 1)) - 1) : '1;

  assign dead_o = (cnt_q >= slot_len);
  assign last_o = (cnt_q >= last_pos);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sec_q  <= '0;
      line_q <= '0;
    end else if (last_o) begin
      if (!hold_i) begin
        cnt_q <= '0;
        if (line_q >= lines_i) begin
          line_q <= '0;
          sec_q  <= (sec_q >= sec_last) ? '0 : sec_q + SEC_BITS'(1);
        end else begin
          line_q <= line_q + LINE_W'(1);
        end
      end
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign cnt_o  = cnt_q;
  assign sec_o  = sec_q;
  assign line_o = line_q;

  // R1: slot position never passes the last dead-time clock
  a_r1_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= last_pos);

  // R7: the line only moves out of a released last dead-time clock
  a_r7_line_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(last_o && !hold_i) |=> $stable(line_q));

  // R7: line index stays inside the configured range
  a_r7_line_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_q <= lines_i);

  // R9: a hold keeps the sequencer parked
  a_r9_hold_park: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && last_o) |=> (last_o && $stable(line_q)));

endmodule

// File: rtl/spwm_chan.sv
module spwm_chan #(
  parameter int SLOT_BITS = 10,
  parameter int SEC_BITS  = 6,
  parameter int CNT_W     = 11,
  parameter int W         = SLOT_BITS + SEC_BITS
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [W-1:0]        value_i,
  input  logic [CNT_W-1:0]    cnt_i,
  input  logic [SEC_BITS-1:0] sec_i,
  input  logic                short_i,
  output logic                oe_o
);

  logic [31:0] on_len;

  assign on_len = spwm_pkg::on_clocks(32'(value_i), 32'(sec_i), short_i, SLOT_BITS, SEC_BITS);
  assign oe_o   = (32'(cnt_i) < on_len);

  // R5: a zero word never lights the channel
  a_r5_zero_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (value_i == '0) |-> !oe_o);

endmodule

// File: rtl/spwm_scan_seq.sv
module spwm_scan_seq #(
  parameter int CH        = 16,
  parameter int SLOT_BITS = 10,
  parameter int SEC_BITS  = 6,
  parameter int DEAD_W    = 6,
  parameter int LINE_W    = 4,
  parameter int W         = SLOT_BITS + SEC_BITS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CH*W-1:0]   gray_i,
  input  logic              short_mode_i,
  input  logic              ghost_en_i,
  input  logic [DEAD_W-1:0] dead_len_i,
  input  logic [LINE_W-1:0] lines_i,
  input  logic              hold_i,
  output logic [CH-1:0]     oe_o,
  output logic [LINE_W-1:0] line_o,
  output logic              ghost_o
);

  localparam int CNT_W = ((SLOT_BITS > DEAD_W) ? SLOT_BITS : DEAD_W) + 1;

  logic [CNT_W-1:0]    cnt;
  logic [SEC_BITS-1:0] sec;
  logic                dead;
  logic                last;

  spwm_timer #(
    .SLOT_BITS(SLOT_BITS), .SEC_BITS(SEC_BITS), .DEAD_W(DEAD_W),
    .LINE_W(LINE_W), .CNT_W(CNT_W)
  ) timer_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .short_i(short_mode_i),
    .dead_len_i(dead_len_i), .lines_i(lines_i), .hold_i(hold_i),
    .cnt_o(cnt), .sec_o(sec), .line_o(line_o), .dead_o(dead), .last_o(last)
  );

  for (genvar c = 0; c < CH; c++) begin : g_chan
    spwm_chan #(
      .SLOT_BITS(SLOT_BITS), .SEC_BITS(SEC_BITS), .CNT_W(CNT_W), .W(W)
    ) chan_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .value_i(gray_i[c*W +: W]),
      .cnt_i(cnt), .sec_i(sec), .short_i(short_mode_i), .oe_o(oe_o[c])
    );
  end

  assign ghost_o = ghost_en_i && dead && rst_ni;

  // R6: every channel is dark in dead time
  a_r6_dead_dark: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dead |-> (oe_o == '0));

  // R8: the strobe stays inside an enabled dead time
  a_r8_strobe_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ghost_o |-> (dead && ghost_en_i));

  // R9: the parked state is always a dead-time state
  a_r9_park_dead: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last |-> dead);

endmodule

// File: tb/spwm_scan_seq_tb_top.sv
module spwm_scan_seq_tb_top;
  localparam int CH = 4, SLOT = 4, SEC = 3, DW = 3, LW = 4, W = SLOT + SEC;

  logic clk = 0, rst_n = 0, short_m = 0, ghost_en = 0, hold = 0;
  logic [DW-1:0] dead_len = 0;
  logic [LW-1:0] lines = 0;
  logic [CH*W-1:0] gray;
  logic [CH-1:0] oe;
  logic [LW-1:0] line;
  logic ghost;
  logic [W-1:0] bank [0:15][0:CH-1];
  int tests = 0, fails = 0, cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  always_comb
    for (int c = 0; c < CH; c++) gray[c*W +: W] = bank[line][c];

  spwm_scan_seq #(.CH(CH), .SLOT_BITS(SLOT), .SEC_BITS(SEC), .DEAD_W(DW), .LINE_W(LW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .gray_i(gray), .short_mode_i(short_m),
    .ghost_en_i(ghost_en), .dead_len_i(dead_len), .lines_i(lines), .hold_i(hold),
    .oe_o(oe), .line_o(line), .ghost_o(ghost));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic fill(input int g, input int off);
    for (int l = 0; l < 16; l++)
      for (int c = 0; c < CH; c++) bank[l][c] = W'((g * CH + c + l * 37 + off) % 128);
  endtask

  // Reset, configure, then compare every clock against the arithmetic model.
  task automatic run_cfg(input bit sm, input int m, input int dl, input bit ge,
                         input int frames, input int off);
    int sl, ns, deff, per, fr;
    fill(0, off);
    @(negedge clk);
    rst_n = 0; short_m = sm; lines = LW'(m - 1); dead_len = DW'(dl); ghost_en = ge;
    repeat (2) @(negedge clk);
    #1;
    check(line == 0, "R10 line in reset", int'(line), 0);
    check(ghost == 0, "R10 ghost in reset", int'(ghost), 0);
    @(negedge clk);
    rst_n = 1;
    sl = sm ? 8 : 16; ns = sm ? 4 : 8; deff = (dl == 0) ? 1 : dl;
    per = sl + deff; fr = ns * m * per;
    for (int n = 0; n < frames * fr; n++) begin
      int slot, pos, ln, sc, hi, lo, rv, v;
      bit eo;
      if (n > 0) @(negedge clk);
      if (n % fr == 0) fill(n / fr, off);
      #1;
      slot = n / per; pos = n % per; ln = slot % m; sc = (slot / m) % ns;
      check(int'(line) == ln, "R7 line", int'(line), ln);
      check(ghost == (ge && pos >= sl), "R8 ghost", int'(ghost), int'(ge && pos >= sl));
      for (int c = 0; c < CH; c++) begin
        v = int'(bank[ln][c]);
        if (sm) begin
          hi = v / 16; lo = (v / 4) % 4; rv = ((sc % 2) * 2) + (sc / 2);
        end else begin
          hi = v / 8; lo = v % 8; rv = ((sc % 2) * 4) + (sc & 2) + (sc / 4);
        end
        eo = (pos < hi + ((rv < lo) ? 1 : 0));
        if (oe[c] != eo) begin
          if (pos >= sl) check(0, "R6 dark dead", int'(oe[c]), int'(eo));
          else if (v == 0) check(0, "R5 zero", int'(oe[c]), int'(eo));
          else if (sm) check(0, "R2 short oe", int'(oe[c]), int'(eo));
          else if (rv < lo) check(0, "R4 extra clock", int'(oe[c]), int'(eo));
          else check(0, "R1 R3 width", int'(oe[c]), int'(eo));
        end else tests++;
      end
    end
  endtask

  task automatic hold_test;
    logic [LW-1:0] held;
    fill(3, 0);
    @(negedge clk);
    rst_n = 0; short_m = 0; lines = 4'd3; dead_len = 3'd2; ghost_en = 1;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    hold = 1;
    repeat (40) @(negedge clk);
    #1 held = line;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk); #1;
      check(line == held, "R9 line frozen", int'(line), int'(held));
      check(oe == '0, "R9 dark while held", int'(oe), 0);
      check(ghost == 1'b1, "R9 R8 strobe while held", int'(ghost), 1);
    end
    hold = 0;
    @(negedge clk); #1;
    check(int'(line) == (int'(held) + 1) % 4, "R9 step after release", int'(line),
          (int'(held) + 1) % 4);
  endtask

  initial begin
    run_cfg(0, 4, 2, 1, 32, 0);   // full mode, every code on every line
    run_cfg(1, 3, 0, 0, 32, 5);   // short mode, minimum dead time
    run_cfg(0, 16, 3, 1, 2, 11);  // all sixteen lines
    hold_test();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule